// File: doc/BRIEF.md
# Stack and Conditional Flow Sequencer

This block is the program-flow half of a small 9-bit accumulator machine. It owns the program counter, a stack pointer with a private stack of return addresses and saved values, a display register, an output-port register and a memory bank select bit. Each cycle in which `instr_valid` is high it takes one decoded 9-bit opcode (the addressing-mode bits already removed), the flag register and a resolved operand word. It then advances or redirects the PC, pushes or pulls the stack, and updates its own registers.

Conditional jumps and calls test a single flag picked by a 3-bit index in the opcode. Each has a variant taken when the flag is set and a variant taken when it is clear. A taken call saves the address that follows the two-word instruction. The accumulator, the arithmetic unit and main memory live outside. The accumulator is read through `acc_in`, and a pull into it is handed back on `acc_wr_en`/`acc_wr_data` in the same cycle.

Top module: `seq_flow_ctrl`

## Requirements
- R1: After reset, the PC, stack pointer, display, output port, bank bit and stack error flag are all zero. The reset is applied asynchronously and its release reaches the logic two clock edges later.
- R2: Pull opcodes read the entry just below the stack pointer and decrement the pointer. 0600 loads the PC with the entry. 0601 loads the display, and 0602 loads the output port. 0603 drives `acc_wr_en` high with the entry on `acc_wr_data` in the same cycle. Apart from 0600, each pull advances the PC by 1.
- R3: Push opcodes write at the stack pointer and then increment it. 0604 stores PC+1, 0614 stores `keys_in`, 0624 stores the output port and 0634 stores `acc_in`. Each push advances the PC by 1.
- R4: Opcodes 0300+f (jump if flag f set) and 0310+f (jump if flag f clear) use bits [2:0] as the flag index f. When taken they load the PC with `operand`; otherwise they advance the PC by 2.
- R5: Opcodes 0320+f (call if set) and 0330+f (call if clear) push PC+2 and load the PC with `operand` when taken. When not taken they advance the PC by 2 and leave the stack untouched.
- R6: Opcode 0400 sets the PC to 1. Opcode 0401 holds the PC at its current value.
- R7: 0402 clears the display, 0403 sets the bank bit, 0404 clears it and 0405 clears the stack pointer, each advancing the PC by 1. 0405 changes neither the stack contents nor the error flag.
- R8: Opcode 0530 loads the PC from `acc_in`, 0510 from `keys_in` and 0520 from `inport_in`.
- R9: A push made at pointer 15 wraps the pointer to 0, and a pull made at pointer 0 wraps it to 15 and reads entry 15. Either one sets `stack_err`, which then stays set until reset.
- R10: Any other opcode below 0400 advances the PC by 2, and any other opcode from 0400 up advances it by 1. Nothing else changes.
- R11: With `instr_valid` low, no register changes and `acc_wr_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Execute `op_code` this cycle |
| op_code | input | 9 | Decoded opcode, mode bits removed |
| operand | input | 9 | Resolved jump or call target |
| flags | input | 8 | Flag register, indexed by opcode bits [2:0] |
| acc_in | input | 9 | Accumulator value |
| keys_in | input | 9 | Key input value |
| inport_in | input | 9 | Input port value |
| pc_out | output | 9 | Program counter |
| sp_out | output | 4 | Stack pointer |
| disp_out | output | 9 | Display register |
| outport_out | output | 9 | Output port register |
| bank_out | output | 1 | Bank select |
| acc_wr_en | output | 1 | Pull into accumulator this cycle |
| acc_wr_data | output | 9 | Value for the accumulator |
| stack_err | output | 1 | Sticky stack wrap error |

## Verification
Two functions fall in the same cycle when a taken call is issued with the pointer at slot 15. The return-address push then coincides with the wrap to 0 and the raising of the error flag. The same happens when a return is issued at pointer 0, where the PC load from the wrapped entry coincides with an underflow. The bench drives the pointer to these edges on purpose, with a run of pushes after a pointer clear and with a return right after a reset. A behavioural model that tracks PC, pointer, stack contents and error flag is compared with the ports every cycle, so a fault in either half of the coincidence is caught in the following cycle.

// File: rtl/seq_flow_pkg.sv
package seq_flow_pkg;

  localparam int OPW = 9;

  localparam logic [OPW-1:0] OP_PULL_PC   = 9'o600;
  localparam logic [OPW-1:0] OP_PULL_DISP = 9'o601;
  localparam logic [OPW-1:0] OP_PULL_OUT  = 9'o602;
  localparam logic [OPW-1:0] OP_PULL_ACC  = 9'o603;
  localparam logic [OPW-1:0] OP_PUSH_PC   = 9'o604;
  localparam logic [OPW-1:0] OP_PUSH_KEYS = 9'o614;
  localparam logic [OPW-1:0] OP_PUSH_OUT  = 9'o624;
  localparam logic [OPW-1:0] OP_PUSH_ACC  = 9'o634;
  localparam logic [OPW-1:0] OP_RESTART   = 9'o400;
  localparam logic [OPW-1:0] OP_HALT      = 9'o401;
  localparam logic [OPW-1:0] OP_DISP_CLR  = 9'o402;
  localparam logic [OPW-1:0] OP_BANK_HI   = 9'o403;
  localparam logic [OPW-1:0] OP_BANK_LO   = 9'o404;
  localparam logic [OPW-1:0] OP_SP_CLR    = 9'o405;
  localparam logic [OPW-1:0] OP_GO_ACC    = 9'o530;
  localparam logic [OPW-1:0] OP_GO_KEYS   = 9'o510;
  localparam logic [OPW-1:0] OP_GO_INPORT = 9'o520;

  typedef enum logic [3:0] {
    PC_INC1, PC_INC2, PC_HOLD, PC_ONE, PC_OPND,
    PC_STACK, PC_ACC, PC_KEYS, PC_INPORT
  } pc_sel_e;

  typedef enum logic [2:0] {
    SRC_PC1, SRC_PC2, SRC_KEYS, SRC_OUT, SRC_ACC
  } push_src_e;

  typedef enum logic [1:0] {
    DST_PC, DST_DISP, DST_OUT, DST_ACC
  } pull_dst_e;

  typedef struct packed {
    logic      push;
    logic      pull;
    push_src_e src;
    pull_dst_e dst;
    pc_sel_e   pc_sel;
    logic      sp_clr;
    logic      disp_clr;
    logic      bank_set;
    logic      bank_clr;
  } seq_ctl_t;

endpackage

// File: rtl/seq_flow_decode.sv
module seq_flow_decode
  import seq_flow_pkg::*;
#(
  parameter int FLAGS = 8
) (
  input  logic [OPW-1:0]   op,
  input  logic [FLAGS-1:0] flags,
  output seq_ctl_t         ctl
);

  localparam int FIW = $clog2(FLAGS);

  logic flag_bit;
  logic want_set;
  logic taken;
  logic is_cond;

  always_comb begin
    flag_bit = flags[op[FIW-1:0]];
    want_set = ~op[3];
    taken    = (flag_bit == want_set);
    is_cond  = (op[8:5] == 4'b0110);
  end

  always_comb begin
    ctl        = '0;
    ctl.src    = SRC_PC1;
    ctl.dst    = DST_PC;
    ctl.pc_sel = PC_INC1;
    case (op)
      OP_PULL_PC:   begin ctl.pull = 1'b1; ctl.dst = DST_PC;   ctl.pc_sel = PC_STACK; end
      OP_PULL_DISP: begin ctl.pull = 1'b1; ctl.dst = DST_DISP; end
      OP_PULL_OUT:  begin ctl.pull = 1'b1; ctl.dst = DST_OUT;  end
      OP_PULL_ACC:  begin ctl.pull = 1'b1; ctl.dst = DST_ACC;  end
      OP_PUSH_PC:   begin ctl.push = 1'b1; ctl.src = SRC_PC1;  end
      OP_PUSH_KEYS: begin ctl.push = 1'b1; ctl.src = SRC_KEYS; end
      OP_PUSH_OUT:  begin ctl.push = 1'b1; ctl.src = SRC_OUT;  end
      OP_PUSH_ACC:  begin ctl.push = 1'b1; ctl.src = SRC_ACC;  end
      OP_RESTART:   ctl.pc_sel = PC_ONE;
      OP_HALT:      ctl.pc_sel = PC_HOLD;
      OP_DISP_CLR:  ctl.disp_clr = 1'b1;
      OP_BANK_HI:   ctl.bank_set = 1'b1;
      OP_BANK_LO:   ctl.bank_clr = 1'b1;
      OP_SP_CLR:    ctl.sp_clr = 1'b1;
      OP_GO_ACC:    ctl.pc_sel = PC_ACC;
      OP_GO_KEYS:   ctl.pc_sel = PC_KEYS;
      OP_GO_INPORT: ctl.pc_sel = PC_INPORT;
      default: begin
        if (is_cond) begin
          if (taken) begin
            ctl.pc_sel = PC_OPND;
            if (op[4]) begin
              ctl.push = 1'b1;
              ctl.src  = SRC_PC2;
            end
          end else begin
            ctl.pc_sel = PC_INC2;
          end
        end else begin
          ctl.pc_sel = op[8] ? PC_INC1 : PC_INC2;
        end
      end
    endcase
  end

endmodule

// File: rtl/seq_flow_stack.sv
module seq_flow_stack #(
  parameter int DW    = 9,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       push,
  input  logic                       pull,
  input  logic                       clr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH)-1:0]   sp,
  output logic                       err
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] SP_TOP = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] sp_below;
  logic [AW-1:0] sp_nxt;
  logic          err_nxt;
  logic          wr_en;

  assign sp_below = sp - AW'(1);
  assign rdata    = mem[sp_below];
  assign wr_en    = en & push;

  always_comb begin
    sp_nxt  = sp;
    err_nxt = err;
    if (en) begin
      if (clr) begin
        sp_nxt = '0;
      end else if (push) begin
        sp_nxt = sp + AW'(1);
        if (sp == SP_TOP) err_nxt = 1'b1;
      end else if (pull) begin
        sp_nxt = sp_below;
        if (sp == '0) err_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp  <= '0;
      err <= 1'b0;
    end else begin
      sp  <= sp_nxt;
      err <= err_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[sp] <= wdata;
  end

  p_one_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !(push && pull));

  p_wrap_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && push && !clr && sp == SP_TOP) |=> (sp == '0 && err));

  p_wrap_pull_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pull && sp == '0) |=> (sp == SP_TOP && err));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_push_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && push && !clr) |=> sp == $past(sp) + AW'(1));

endmodule

// File: rtl/seq_flow_pc.sv
module seq_flow_pc
  import seq_flow_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  pc_sel_e       sel,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] stk,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] keys,
  input  logic [DW-1:0] inport,
  output logic [DW-1:0] pc
);

  logic [DW-1:0] pc_nxt;

  always_comb begin
    pc_nxt = pc;
    if (en) begin
      case (sel)
        PC_INC1:   pc_nxt = pc + DW'(1);
        PC_INC2:   pc_nxt = pc + DW'(2);
        PC_HOLD:   pc_nxt = pc;
        PC_ONE:    pc_nxt = DW'(1);
        PC_OPND:   pc_nxt = opnd;
        PC_STACK:  pc_nxt = stk;
        PC_ACC:    pc_nxt = acc;
        PC_KEYS:   pc_nxt = keys;
        PC_INPORT: pc_nxt = inport;
        default:   pc_nxt = pc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_nxt;
  end

  p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sel == PC_HOLD) |=> pc == $past(pc));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sel == PC_ONE) |=> pc == DW'(1));

  p_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sel == PC_OPND) |=> pc == $past(opnd));

endmodule

// File: rtl/seq_flow_ctrl.sv
module seq_flow_ctrl
  import seq_flow_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 16,
  parameter int FLAGS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       instr_valid,
  input  logic [OPW-1:0]             op_code,
  input  logic [DW-1:0]              operand,
  input  logic [FLAGS-1:0]           flags,
  input  logic [DW-1:0]              acc_in,
  input  logic [DW-1:0]              keys_in,
  input  logic [DW-1:0]              inport_in,
  output logic [DW-1:0]              pc_out,
  output logic [$clog2(DEPTH)-1:0]   sp_out,
  output logic [DW-1:0]              disp_out,
  output logic [DW-1:0]              outport_out,
  output logic                       bank_out,
  output logic                       acc_wr_en,
  output logic [DW-1:0]              acc_wr_data,
  output logic                       stack_err
);

  logic [1:0]    rst_sync;
  logic          rst_ni;
  seq_ctl_t      ctl;
  logic [DW-1:0] stk_rd;
  logic [DW-1:0] push_data;
  logic [DW-1:0] disp_nxt;
  logic [DW-1:0] out_nxt;
  logic          bank_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  seq_flow_decode #(.FLAGS(FLAGS)) u_decode (
    .op    (op_code),
    .flags (flags),
    .ctl   (ctl)
  );

  always_comb begin
    case (ctl.src)
      SRC_PC1:  push_data = pc_out + DW'(1);
      SRC_PC2:  push_data = pc_out + DW'(2);
      SRC_KEYS: push_data = keys_in;
      SRC_OUT:  push_data = outport_out;
      SRC_ACC:  push_data = acc_in;
      default:  push_data = acc_in;
    endcase
  end

  seq_flow_stack #(.DW(DW), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_ni),
    .en    (instr_valid),
    .push  (ctl.push),
    .pull  (ctl.pull),
    .clr   (ctl.sp_clr),
    .wdata (push_data),
    .rdata (stk_rd),
    .sp    (sp_out),
    .err   (stack_err)
  );

  seq_flow_pc #(.DW(DW)) u_pc (
    .clk    (clk),
    .rst_n  (rst_ni),
    .en     (instr_valid),
    .sel    (ctl.pc_sel),
    .opnd   (operand),
    .stk    (stk_rd),
    .acc    (acc_in),
    .keys   (keys_in),
    .inport (inport_in),
    .pc     (pc_out)
  );

  always_comb begin
    disp_nxt = disp_out;
    out_nxt  = outport_out;
    bank_nxt = bank_out;
    if (instr_valid) begin
      if (ctl.disp_clr) disp_nxt = '0;
      if (ctl.pull && ctl.dst == DST_DISP) disp_nxt = stk_rd;
      if (ctl.pull && ctl.dst == DST_OUT)  out_nxt  = stk_rd;
      if (ctl.bank_set) bank_nxt = 1'b1;
      if (ctl.bank_clr) bank_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_out    <= '0;
      outport_out <= '0;
      bank_out    <= 1'b0;
    end else begin
      disp_out    <= disp_nxt;
      outport_out <= out_nxt;
      bank_out    <= bank_nxt;
    end
  end

  assign acc_wr_en   = instr_valid & ctl.pull & (ctl.dst == DST_ACC);
  assign acc_wr_data = stk_rd;

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    !instr_valid |=> ($stable(pc_out) && $stable(sp_out) && $stable(disp_out)
                      && $stable(outport_out) && $stable(bank_out)));

  p_acc_wr_valid_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_wr_en |-> instr_valid);

  p_pull_disp_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (instr_valid && op_code == OP_PULL_DISP) |=> disp_out == $past(stk_rd));

  p_bank_hi_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (instr_valid && op_code == OP_BANK_HI) |=> bank_out);

endmodule

// File: tb/seq_flow_ctrl_bench.sv
`timescale 1ns/1ps
module seq_flow_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       instr_valid;
  logic [8:0] op_code;
  logic [8:0] operand;
  logic [7:0] flags;
  logic [8:0] acc_in, keys_in, inport_in;
  logic [8:0] pc_out, disp_out, outport_out, acc_wr_data;
  logic [3:0] sp_out;
  logic       bank_out, acc_wr_en, stack_err;

  always #4 clk = ~clk;

  seq_flow_ctrl u_seq_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op_code(op_code),
    .operand(operand), .flags(flags), .acc_in(acc_in), .keys_in(keys_in),
    .inport_in(inport_in), .pc_out(pc_out), .sp_out(sp_out), .disp_out(disp_out),
    .outport_out(outport_out), .bank_out(bank_out), .acc_wr_en(acc_wr_en),
    .acc_wr_data(acc_wr_data), .stack_err(stack_err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_pc, m_sp, m_disp, m_out, m_bank, m_err;
  int m_mem [16];
  string last_tag = "R1";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_state();
    chk(last_tag, "pc", int'(pc_out), m_pc);
    chk(last_tag, "sp", int'(sp_out), m_sp);
    chk(last_tag, "display", int'(disp_out), m_disp);
    chk(last_tag, "outport", int'(outport_out), m_out);
    chk(last_tag, "bank", int'(bank_out), m_bank);
    chk(last_tag, "stack_err", int'(stack_err), m_err);
  endtask

  task automatic model_reset();
    m_pc = 0; m_sp = 0; m_disp = 0; m_out = 0; m_bank = 0; m_err = 0;
  endtask

  function automatic void m_push(int v);
    m_mem[m_sp] = v & 511;
    if (m_sp == 15) m_err = 1;
    m_sp = (m_sp + 1) & 15;
  endfunction

  function automatic int m_pull();
    if (m_sp == 0) m_err = 1;
    m_sp = (m_sp - 1) & 15;
    return m_mem[m_sp];
  endfunction

  task automatic issue(bit v, int op, int opnd, int fl, int a, int k, int ip, string tag);
    int exp_wr_en, exp_wr_data, val, cls, bitv, want;
    @(negedge clk);
    cmp_state();
    instr_valid = v; op_code = op[8:0]; operand = opnd[8:0];
    flags = fl[7:0]; acc_in = a[8:0]; keys_in = k[8:0]; inport_in = ip[8:0];
    #1;
    exp_wr_en = (v && op == 'o603) ? 1 : 0;
    exp_wr_data = m_mem[(m_sp - 1) & 15];
    chk(tag, "acc_wr_en", int'(acc_wr_en), exp_wr_en);
    if (exp_wr_en == 1) chk(tag, "acc_wr_data", int'(acc_wr_data), exp_wr_data);
    if (v) begin
      case (op)
        'o600: m_pc = m_pull();
        'o601: begin m_disp = m_pull(); m_pc = m_pc + 1; end
        'o602: begin m_out = m_pull(); m_pc = m_pc + 1; end
        'o603: begin val = m_pull(); m_pc = m_pc + 1; end
        'o604: begin m_push(m_pc + 1); m_pc = m_pc + 1; end
        'o614: begin m_push(k); m_pc = m_pc + 1; end
        'o624: begin m_push(m_out); m_pc = m_pc + 1; end
        'o634: begin m_push(a); m_pc = m_pc + 1; end
        'o400: m_pc = 1;
        'o401: ;
        'o402: begin m_disp = 0; m_pc = m_pc + 1; end
        'o403: begin m_bank = 1; m_pc = m_pc + 1; end
        'o404: begin m_bank = 0; m_pc = m_pc + 1; end
        'o405: begin m_sp = 0; m_pc = m_pc + 1; end
        'o530: m_pc = a;
        'o510: m_pc = k;
        'o520: m_pc = ip;
        default: begin
          if (op >= 'o300 && op <= 'o337) begin
            cls = (op >> 3) & 3;
            bitv = (fl >> (op & 7)) & 1;
            want = (cls % 2 == 0) ? 1 : 0;
            if (bitv == want) begin
              if (cls >= 2) m_push(m_pc + 2);
              m_pc = opnd;
            end else begin
              m_pc = m_pc + 2;
            end
          end else begin
            m_pc = m_pc + ((op < 'o400) ? 2 : 1);
          end
        end
      endcase
      m_pc = m_pc & 511;
    end
    last_tag = tag;
  endtask

  task automatic do_reset();
    @(negedge clk);
    cmp_state();
    rst_n = 1'b0; instr_valid = 1'b0;
    model_reset();
    last_tag = "R1";
    @(negedge clk);
    cmp_state();
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) issue(0, 0, 0, 0, 0, 0, 0, "R1");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = 0;
    model_reset();
    rst_n = 1'b0; instr_valid = 1'b0; op_code = '0; operand = '0;
    flags = '0; acc_in = '0; keys_in = '0; inport_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp_state();
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) issue(0, 0, 0, 0, 0, 0, 0, "R1");

    // R3 pushes of accumulator, keys, out port and PC
    issue(1, 'o634, 0, 0, 'h005, 0, 0, "R3");
    issue(1, 'o634, 0, 0, 'h1F3, 0, 0, "R3");
    issue(1, 'o614, 0, 0, 0, 'h1AB, 0, "R3");
    issue(1, 'o624, 0, 0, 0, 0, 0, "R3");
    // R2 pulls into out port, display, accumulator
    issue(1, 'o602, 0, 0, 0, 0, 0, "R2");
    issue(1, 'o601, 0, 0, 0, 0, 0, "R2");
    issue(1, 'o603, 0, 0, 0, 0, 0, "R2");
    issue(1, 'o624, 0, 0, 0, 0, 0, "R3");
    issue(1, 'o603, 0, 0, 0, 0, 0, "R2");
    issue(1, 'o603, 0, 0, 0, 0, 0, "R2");
    // R3 push PC then R2 return
    issue(1, 'o604, 0, 0, 0, 0, 0, "R3");
    issue(1, 'o011, 0, 0, 0, 0, 0, "R10");
    issue(1, 'o600, 0, 0, 0, 0, 0, "R2");
    // R4 jumps on flags 0101_0010
    issue(1, 'o302, 'h040, 'h52, 0, 0, 0, "R4");
    issue(1, 'o301, 'h040, 'h52, 0, 0, 0, "R4");
    issue(1, 'o312, 'h0A0, 'h52, 0, 0, 0, "R4");
    issue(1, 'o311, 'h0C0, 'h52, 0, 0, 0, "R4");
    issue(1, 'o316, 'h0C0, 'h52, 0, 0, 0, "R4");
    // R5 calls
    issue(1, 'o324, 'h100, 'h52, 0, 0, 0, "R5");
    issue(1, 'o334, 'h120, 'h52, 0, 0, 0, "R5");
    issue(1, 'o327, 'h130, 'h52, 0, 0, 0, "R5");
    issue(1, 'o337, 'h150, 'h52, 0, 0, 0, "R5");
    issue(1, 'o600, 0, 0, 0, 0, 0, "R2");
    issue(1, 'o600, 0, 0, 0, 0, 0, "R2");
    // R6 restart and halt
    issue(1, 'o400, 0, 0, 0, 0, 0, "R6");
    issue(1, 'o401, 0, 0, 0, 0, 0, "R6");
    issue(1, 'o401, 0, 0, 0, 0, 0, "R6");
    // R7 display clear, bank, pointer clear
    issue(1, 'o624, 0, 0, 0, 0, 0, "R3");
    issue(1, 'o634, 0, 0, 'h077, 0, 0, "R3");
    issue(1, 'o601, 0, 0, 0, 0, 0, "R2");
    issue(1, 'o402, 0, 0, 0, 0, 0, "R7");
    issue(1, 'o403, 0, 0, 0, 0, 0, "R7");
    issue(1, 'o404, 0, 0, 0, 0, 0, "R7");
    issue(1, 'o403, 0, 0, 0, 0, 0, "R7");
    issue(1, 'o405, 0, 0, 0, 0, 0, "R7");
    // R8 computed jumps
    issue(1, 'o530, 0, 0, 'h123, 'h0, 'h0, "R8");
    issue(1, 'o510, 0, 0, 'h0, 'h045, 'h0, "R8");
    issue(1, 'o520, 0, 0, 'h0, 'h0, 'h1FE, "R8");
    // R10 other opcodes
    issue(1, 'o200, 0, 0, 0, 0, 0, "R10");
    issue(1, 'o107, 0, 0, 0, 0, 0, "R10");
    issue(1, 'o700, 0, 0, 0, 0, 0, "R10");
    issue(1, 'o501, 0, 0, 0, 0, 0, "R10");
    issue(1, 'o345, 0, 0, 0, 0, 0, "R10");
    // R11 nothing changes while invalid
    issue(0, 'o634, 0, 0, 'h1FF, 0, 0, "R11");
    issue(0, 'o603, 0, 0, 0, 0, 0, "R11");
    issue(0, 'o400, 0, 0, 0, 0, 0, "R11");
    // R9 overflow: pointer clear, 15 pushes, then taken call at slot 15
    issue(1, 'o405, 0, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 15; i++) issue(1, 'o634, 0, 0, i * 7 + 3, 0, 0, "R9");
    issue(1, 'o320, 'h1C0, 'h01, 0, 0, 0, "R9");
    issue(1, 'o634, 0, 0, 'h0AA, 0, 0, "R9");
    issue(1, 'o405, 0, 0, 0, 0, 0, "R9");
    issue(1, 'o401, 0, 0, 0, 0, 0, "R9");
    // R9 underflow: after reset, return at pointer 0 reads wrapped slot 15
    do_reset();
    issue(1, 'o600, 0, 0, 0, 0, 0, "R9");
    issue(1, 'o603, 0, 0, 0, 0, 0, "R9");
    issue(1, 'o634, 0, 0, 'h011, 0, 0, "R9");
    issue(0, 0, 0, 0, 0, 0, 0, "R9");
    @(negedge clk);
    cmp_state();

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule